// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block stores the operating mode of a four-bank, 16-bit synchronous DRAM and produces the column address for every beat of a read or write burst. A mode-register-set command loads the burst length, the beat ordering, the read latency and the write mode from the address and bank lines. A reserved or malformed code is refused: the stored mode is kept and an error strobe is raised.

A read or write command gives a start column. From the next cycle the block presents one column address per clock until the programmed number of beats has gone out. It supports sequential ordering that wraps inside an aligned block, interleaved ordering (start XOR beat index), and a full-page length that wraps over the whole row and runs until it is stopped. A burst-stop command, a new read or write, or a mode-register-set ends the running burst on any cycle. If the single-write mode is set, writes take one beat and reads still burst.

Top module: `sdram_mode_burst`

## Requirements
- R1: After reset the burst output is idle (`col_vld`=0, `mode_err`=0), and the stored mode is length code 000, sequential ordering, latency code 011, burst writes.
- R2: Command codes on `cmd_op` are 000 idle, 001 mode set, 010 read, 011 write and 100 stop; every other code acts as idle. An accepted mode set loads the length code from address bits 2:0, the ordering from bit 3 (1 = interleaved), the latency code from bits 6:4 and the write mode from bit 9 (1 = single write). The new mode shows on the `cfg_*` outputs in the cycle after the command.
- R3: A mode set is refused when any of the following holds: the length code is 100, 101 or 110; the length code is 111 together with interleaved ordering; the latency code is neither 010 nor 011; or the bank lines or address bits 7, 8, 10 or 11 are non-zero. A refused mode set leaves the stored mode unchanged and holds `mode_err` high for exactly the following cycle.
- R4: A read or write command sampled at a clock edge drives `col_vld`=1 in the next cycle. In that cycle `col_addr` equals the start column (the low 8 address bits) and `col_wr` is 1 for a write. One address follows per clock for 1, 2, 4 or 8 beats (length codes 000 to 011). `col_last` marks the final beat, and `col_vld` falls in the cycle after it.
- R5: In sequential ordering, beat k has the address base + ((start + k) mod N). Here N is the burst length and base is the start column rounded down to a multiple of N.
- R6: In interleaved ordering, beat k has the address start XOR k.
- R7: With length code 111 the address steps by one per clock and wraps from 255 to 0. The burst does not end by itself, and `col_last` stays low.
- R8: When the single-write mode is set, a write burst has exactly one beat, with `col_last` high. A read still runs for the programmed length.
- R9: A stop command ends an active burst, so `col_vld` is 0 in the next cycle. A stop while idle changes nothing.
- R10: A read or write that arrives during an active burst restarts the sequence at its own start column in the next cycle.
- R11: Any command in the cycle right after a mode set is ignored, including a refused mode set, and the command in the cycle after that is accepted. A mode set also ends an active burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 12 | Address lines: mode fields or start column |
| cmd_bank | input | 2 | Bank lines; must be zero for a mode set |
| col_vld | output | 1 | A burst beat is present |
| col_addr | output | 8 | Column address of the current beat |
| col_wr | output | 1 | The current burst is a write |
| col_last | output | 1 | Final beat of a finite burst |
| cfg_cas_lat | output | 3 | Stored read-latency code |
| cfg_len_code | output | 3 | Stored burst-length code |
| cfg_interleave | output | 1 | Stored ordering, 1 = interleaved |
| cfg_single_wr | output | 1 | Stored write mode, 1 = single-beat writes |
| mode_err | output | 1 | One-cycle strobe after a refused mode set |

## Verification
Sequential bursts of lengths 2, 4 and 8 are started from misaligned columns, so a wrap at the burst size can be told apart from a plain increment or a wrap at some other size. The same start columns are then replayed with interleaved ordering, whose XOR pattern differs from the sequential one whenever the start is not aligned. A full-page run longer than a row checks the 255-to-0 rollover. Stops, restarts, commands in the lockout cycle and each class of reserved field are driven to cut or corrupt bursts at chosen beats.

// File: rtl/sdram_mb_pkg.sv
package sdram_mb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'b000,
    OP_MSET = 3'b001,
    OP_RD   = 3'b010,
    OP_WR   = 3'b011,
    OP_STOP = 3'b100
  } op_e;

  typedef struct packed {
    logic       single_wr;
    logic [2:0] lat;
    logic       ilv;
    logic [2:0] len;
  } mode_t;

  localparam mode_t MODE_RST = '{single_wr: 1'b0, lat: 3'b011, ilv: 1'b0, len: 3'b000};

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_mb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   bank,
  output mode_t             mode_q,
  output logic              mode_err,
  output logic              cmd_ok,
  output logic              mset_take
);

  logic hold_q;
  logic fields_ok;

  function automatic logic mset_legal(input logic [ADDR_W-1:0] a, input logic [BA_W-1:0] b);
    logic len_ok, lat_ok, zero_ok;
    len_ok  = (a[2] == 1'b0) || (a[2:0] == 3'b111 && a[3] == 1'b0);
    lat_ok  = (a[6:4] == 3'b010) || (a[6:4] == 3'b011);
    zero_ok = (b == '0) && (a[8:7] == 2'b00) && (a[ADDR_W-1:10] == '0);
    return len_ok && lat_ok && zero_ok;
  endfunction

  assign cmd_ok    = !hold_q;
  assign mset_take = cmd_ok && (op == OP_MSET);
  assign fields_ok = mset_legal(addr, bank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      mode_q   <= MODE_RST;
      mode_err <= 1'b0;
    end else begin
      hold_q   <= mset_take;
      mode_err <= mset_take && !fields_ok;
      if (mset_take && fields_ok) begin
        mode_q.len       <= addr[2:0];
        mode_q.ilv       <= addr[3];
        mode_q.lat       <= addr[6:4];
        mode_q.single_wr <= addr[9];
      end
    end
  end

  a_r11_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    mset_take |=> !cmd_ok && !mset_take);
  a_r3_keep_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $stable(mode_q));
  a_r7_full_seq_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.len == 3'b111) |-> !mode_q.ilv);

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_mb_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_rd,
  input  logic             go_wr,
  input  logic             halt,
  input  mode_t            mode_q,
  input  logic [COL_W-1:0] start_col,
  output logic             col_vld,
  output logic [COL_W-1:0] col_addr,
  output logic             col_wr,
  output logic             col_last
);

  localparam int LGW = $clog2(COL_W + 1);

  logic             act_q, full_q, ilv_q, wr_q;
  logic [COL_W-1:0] base_q, beat_q;
  logic [LGW-1:0]   lg_q, lg_new;
  logic [COL_W-1:0] mask;
  logic             go_any, single_go;

  function automatic logic [COL_W-1:0] lg_mask(input logic [LGW-1:0] lg);
    logic [COL_W:0] m;
    m = ({{COL_W{1'b0}}, 1'b1} << lg) - 1'b1;
    return m[COL_W-1:0];
  endfunction

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] s, input logic [COL_W-1:0] k,
                                                input logic [COL_W-1:0] m, input logic il);
    logic [COL_W-1:0] sum;
    sum = s + k;
    if (il) return s ^ (k & m);
    return (s & ~m) | (sum & m);
  endfunction

  always_comb begin
    case (mode_q.len)
      3'b001:  lg_new = LGW'(1);
      3'b010:  lg_new = LGW'(2);
      3'b011:  lg_new = LGW'(3);
      3'b111:  lg_new = LGW'(COL_W);
      default: lg_new = '0;
    endcase
  end

  assign go_any    = go_rd || go_wr;
  assign single_go = go_wr && mode_q.single_wr;
  assign mask      = lg_mask(lg_q);
  assign col_vld   = act_q;
  assign col_wr    = wr_q;
  assign col_addr  = beat_col(base_q, beat_q, mask, ilv_q);
  assign col_last  = act_q && !full_q && (beat_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      lg_q   <= '0;
    end else if (go_any) begin
      act_q  <= 1'b1;
      wr_q   <= go_wr;
      base_q <= start_col;
      beat_q <= '0;
      ilv_q  <= mode_q.ilv;
      lg_q   <= single_go ? '0 : lg_new;
      full_q <= !single_go && (mode_q.len == 3'b111);
    end else if (halt || col_last) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |=> col_vld && (col_addr == $past(start_col)) && (col_wr == $past(go_wr)));
  a_r5_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !full_q) |-> (((col_addr ^ base_q) & ~mask) == '0));
  a_r7_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && full_q && $past(col_vld) && !$past(go_any)) |-> (col_addr == $past(col_addr) + 1'b1));
  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && col_wr && mode_q.single_wr) |-> col_last);
  a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !go_any) |=> !col_vld);

endmodule

// File: rtl/sdram_mode_burst.sv
module sdram_mode_burst
  import sdram_mb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BA_W-1:0]   cmd_bank,
  output logic              col_vld,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_wr,
  output logic              col_last,
  output logic [2:0]        cfg_cas_lat,
  output logic [2:0]        cfg_len_code,
  output logic              cfg_interleave,
  output logic              cfg_single_wr,
  output logic              mode_err
);

  mode_t mode_q;
  logic  cmd_ok, mset_take, go_rd, go_wr, halt;

  sdram_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .op(cmd_op), .addr(cmd_addr), .bank(cmd_bank),
    .mode_q(mode_q), .mode_err(mode_err), .cmd_ok(cmd_ok), .mset_take(mset_take)
  );

  assign go_rd = cmd_ok && (cmd_op == OP_RD);
  assign go_wr = cmd_ok && (cmd_op == OP_WR);
  assign halt  = (cmd_ok && (cmd_op == OP_STOP)) || mset_take;

  sdram_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_rd(go_rd), .go_wr(go_wr), .halt(halt),
    .mode_q(mode_q), .start_col(cmd_addr[COL_W-1:0]),
    .col_vld(col_vld), .col_addr(col_addr), .col_wr(col_wr), .col_last(col_last)
  );

  assign cfg_cas_lat    = mode_q.lat;
  assign cfg_len_code   = mode_q.len;
  assign cfg_interleave = mode_q.ilv;
  assign cfg_single_wr  = mode_q.single_wr;

endmodule

// File: tb/sdram_mode_burst_tb.sv
module sdram_mode_burst_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = 3'b000;
  logic [11:0] cmd_addr = '0;
  logic [1:0]  cmd_bank = '0;
  logic        col_vld, col_wr, col_last, cfg_interleave, cfg_single_wr, mode_err;
  logic [7:0]  col_addr;
  logic [2:0]  cfg_cas_lat, cfg_len_code;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sdram_mode_burst dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
    .col_vld(col_vld), .col_addr(col_addr), .col_wr(col_wr), .col_last(col_last),
    .cfg_cas_lat(cfg_cas_lat), .cfg_len_code(cfg_len_code), .cfg_interleave(cfg_interleave),
    .cfg_single_wr(cfg_single_wr), .mode_err(mode_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(input logic [2:0] op, input logic [11:0] a, input logic [1:0] b);
    cmd_op = op; cmd_addr = a; cmd_bank = b;
  endtask

  function automatic int mset_word(input int len, input int ilv, input int lat, input int swr);
    return len | (ilv << 3) | (lat << 4) | (swr << 9);
  endfunction

  function automatic int exp_col(input int s, input int k, input int n, input int ilv, input int full);
    if (full != 0) return (s + k) % 256;
    if (ilv != 0) return s ^ k;
    return (s - (s % n)) + ((s + k) % n);
  endfunction

  task automatic t_mset(input int len, input int ilv, input int lat, input int swr);
    step(); drive(3'b001, 12'(mset_word(len, ilv, lat, swr)), 2'b00);
    step(); drive(3'b000, 12'h000, 2'b00);
    check("R2 len", int'(cfg_len_code), len);
    check("R2 ilv", int'(cfg_interleave), ilv);
    check("R2 lat", int'(cfg_cas_lat), lat);
    check("R2 swr", int'(cfg_single_wr), swr);
    check("R2 no err", int'(mode_err), 0);
  endtask

  task automatic t_burst(input string req, input logic [2:0] op, input int s,
                         input int beats, input int ilv);
    step(); drive(op, 12'(s), 2'b00);
    for (int k = 0; k < beats; k++) begin
      step();
      if (k == 0) drive(3'b000, 12'h000, 2'b00);
      check({req, " vld"}, int'(col_vld), 1);
      check({req, " addr"}, int'(col_addr), exp_col(s, k, beats, ilv, 0));
      check({req, " wr"}, int'(col_wr), (op == 3'b011) ? 1 : 0);
      check({req, " last"}, int'(col_last), (k == beats - 1) ? 1 : 0);
    end
    step();
    check({req, " end"}, int'(col_vld), 0);
  endtask

  task automatic t_bad(input string req, input int word, input int bank);
    int l0, i0, c0, s0;
    l0 = cfg_len_code; i0 = cfg_interleave; c0 = cfg_cas_lat; s0 = cfg_single_wr;
    step(); drive(3'b001, 12'(word), 2'(bank));
    step(); drive(3'b000, 12'h000, 2'b00);
    check({req, " err"}, int'(mode_err), 1);
    check({req, " len kept"}, int'(cfg_len_code), l0);
    check({req, " ilv kept"}, int'(cfg_interleave), i0);
    check({req, " lat kept"}, int'(cfg_cas_lat), c0);
    check({req, " swr kept"}, int'(cfg_single_wr), s0);
    step();
    check({req, " err one cycle"}, int'(mode_err), 0);
  endtask

  task automatic t_full_page();
    step(); drive(3'b010, 12'd250, 2'b00);
    for (int k = 0; k < 270; k++) begin
      step();
      if (k == 0) drive(3'b000, 12'h000, 2'b00);
      check("R7 vld", int'(col_vld), 1);
      check("R7 addr", int'(col_addr), exp_col(250, k, 256, 0, 1));
      check("R7 no last", int'(col_last), 0);
    end
    drive(3'b100, 12'h000, 2'b00);
    step(); drive(3'b000, 12'h000, 2'b00);
    check("R9 stop ends full page", int'(col_vld), 0);
  endtask

  task automatic t_stop_restart();
    step(); drive(3'b010, 12'd13, 2'b00);
    step(); drive(3'b000, 12'h000, 2'b00);
    step();
    check("R10 pre addr", int'(col_addr), exp_col(13, 1, 8, 0, 0));
    drive(3'b011, 12'd34, 2'b00);
    step(); drive(3'b000, 12'h000, 2'b00);
    check("R10 restart vld", int'(col_vld), 1);
    check("R10 restart addr", int'(col_addr), 34);
    check("R10 restart wr", int'(col_wr), 1);
    step();
    check("R10 second beat", int'(col_addr), exp_col(34, 1, 8, 0, 0));
    drive(3'b100, 12'h000, 2'b00);
    step(); drive(3'b100, 12'h000, 2'b00);
    check("R9 stop", int'(col_vld), 0);
    step(); drive(3'b000, 12'h000, 2'b00);
    check("R9 stop idle", int'(col_vld), 0);
    check("R9 stop idle mode", int'(cfg_len_code), 3);
  endtask

  task automatic t_lockout();
    step(); drive(3'b010, 12'd5, 2'b00);
    step(); drive(3'b001, 12'(mset_word(3, 0, 3, 0)), 2'b00);
    check("R11 burst running", int'(col_vld), 1);
    step(); drive(3'b010, 12'd77, 2'b00);
    check("R11 mode set ends burst", int'(col_vld), 0);
    step(); drive(3'b010, 12'd90, 2'b00);
    check("R11 locked cmd ignored", int'(col_vld), 0);
    step(); drive(3'b000, 12'h000, 2'b00);
    check("R11 accepted vld", int'(col_vld), 1);
    check("R11 accepted addr", int'(col_addr), 90);
    step(); drive(3'b100, 12'h000, 2'b00);
    step(); drive(3'b000, 12'h000, 2'b00);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 vld", int'(col_vld), 0);
    check("R1 err", int'(mode_err), 0);
    check("R1 len", int'(cfg_len_code), 0);
    check("R1 ilv", int'(cfg_interleave), 0);
    check("R1 lat", int'(cfg_cas_lat), 3);
    check("R1 swr", int'(cfg_single_wr), 0);
    t_burst("R4 len1", 3'b010, 200, 1, 0);

    t_mset(1, 0, 2, 0);  t_burst("R5 seq2", 3'b010, 7, 2, 0);
    t_mset(2, 0, 2, 0);  t_burst("R5 seq4", 3'b011, 22, 4, 0);
    t_mset(3, 0, 3, 0);  t_burst("R5 seq8", 3'b010, 45, 8, 0);
    t_burst("R4 seq8 aligned", 3'b011, 16, 8, 0);
    t_mset(2, 1, 3, 0);  t_burst("R6 ilv4", 3'b010, 22, 4, 1);
    t_mset(3, 1, 2, 0);  t_burst("R6 ilv8", 3'b011, 45, 8, 1);

    t_mset(3, 0, 3, 1);
    t_burst("R8 single write", 3'b011, 45, 1, 0);
    t_burst("R8 read still bursts", 3'b010, 45, 8, 0);

    t_mset(3, 0, 3, 0);
    t_bad("R3 len 100", mset_word(4, 0, 2, 1), 0);
    t_bad("R3 len 110", mset_word(6, 0, 2, 0), 0);
    t_bad("R3 full ilv", mset_word(7, 1, 2, 0), 0);
    t_bad("R3 lat 001", mset_word(1, 0, 1, 0), 0);
    t_bad("R3 lat 100", mset_word(1, 0, 4, 0), 0);
    t_bad("R3 bank", mset_word(1, 0, 2, 0), 2);
    t_bad("R3 bit7", mset_word(1, 0, 2, 0) | 12'h080, 0);
    t_bad("R3 bit10", mset_word(1, 0, 2, 0) | 12'h400, 0);
    t_burst("R3 mode kept burst", 3'b010, 45, 8, 0);

    t_stop_restart();
    t_lockout();
    t_mset(7, 0, 3, 0);
    t_full_page();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule